// File: doc/BRIEF.md
# Protected Save-Area Lock Register

This block is one byte-wide configuration register that guards a protected window at the management-mode save-area base. Firmware first probes for support by writing an all-ones query byte. A register that supports the feature answers with an "in RAM" code and from then on accepts only one writable bit, the lock bit. Setting that bit closes the register. The window then becomes a blackhole for ordinary accesses and is opened to management accesses. The register stays frozen until reset.

A parameter removes the feature. The register is then an ordinary byte of storage and both window enables stay low. The block only produces the enables. Routing memory traffic and signalling management mode are the jobs of neighbouring logic.

Top module: `smb_lock_reg`

## Requirements
- R1: After reset the register reads 0x00, and both `blackhole_en` and `mgmt_window_en` are 0.
- R2: With `FEATURE_EN`=0, every write stores `wr_data` unchanged, and both enables stay 0.
- R3: With the feature on and no probe done yet, a write of 0xFF makes the register read 0x01. From then on only bit 1 is writable.
- R4: Before the probe, a write of any value other than 0xFF is discarded and the register reads 0x00, including a write of 0x02.
- R5: After the probe, a write with bit 1 set locks the register. It then reads exactly 0x02, whatever the other bits of the write.
- R6: After the probe, a write with bit 1 clear leaves the register at 0x01 and unlocked, and the other bits of the write are ignored.
- R7: Once locked, the register ignores every write, including 0xFF and 0x00. Only reset unlocks it.
- R8: `blackhole_en` and `mgmt_window_en` are both 1 exactly while the register is locked. They rise on the clock edge that takes the locking write.
- R9: A read strobe returns the register value on `rd_data`, with a one-cycle `rd_valid` pulse, on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Configuration read strobe |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid pulse |
| reg_value | output | 8 | Current register contents |
| blackhole_en | output | 1 | Hide the window from ordinary accesses |
| mgmt_window_en | output | 1 | Show the window to management accesses |

## Verification
The handshake is exercised in each of its three phases with the same small set of bytes: 0xFF, 0x02, 0x00, 0x55 and 0xFD.
- In the open phase, 0x02 shows that a premature lock is discarded, and 0x55 tells a discard apart from a store.
- In the probed phase, 0xFD and 0x00 confirm that non-lock bits are masked. 0xFF is sent from a fresh probe to show that it locks through its bit 1 rather than re-probing.
- In the locked phase, the same bytes prove the register is frozen, and a reset shows the lock clears.
- A second instance with the feature off receives the same stream, which separates plain storage from the handshake.

// File: rtl/smb_lock_pkg.sv
package smb_lock_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    PH_OPEN   = 2'd0,
    PH_PROBED = 2'd1,
    PH_LOCKED = 2'd2
  } phase_t;

  // write-enable mask for each handshake phase
  function automatic logic [REG_W-1:0] phase_mask(phase_t ph, logic [REG_W-1:0] lock_mask);
    case (ph)
      PH_OPEN:   phase_mask = '1;
      PH_PROBED: phase_mask = lock_mask;
      default:   phase_mask = '0;
    endcase
  endfunction

  // keep unwritable bits, take writable bits from the new byte
  function automatic logic [REG_W-1:0] merge_bits(logic [REG_W-1:0] old_v,
                                                  logic [REG_W-1:0] new_v,
                                                  logic [REG_W-1:0] mask);
    merge_bits = (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/smb_lock_ctrl.sv
module smb_lock_ctrl
  import smb_lock_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] QUERY_VAL = 8'hFF,
  parameter logic [W-1:0] INRAM_VAL = 8'h01,
  parameter int LOCK_BIT = 1
) (
  input  phase_t       cur_phase,
  input  logic [W-1:0] cur_value,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output phase_t       nxt_phase,
  output logic [W-1:0] nxt_value,
  output logic         ev_query,
  output logic         ev_discard,
  output logic         ev_lock
);
  localparam logic [W-1:0] LOCK_MASK = W'(1) << LOCK_BIT;

  logic [W-1:0] merged;

  assign merged     = merge_bits(cur_value, wr_data, phase_mask(cur_phase, LOCK_MASK));
  assign ev_query   = wr_en && (merged == QUERY_VAL);
  assign ev_discard = wr_en && !ev_query && (cur_phase == PH_OPEN);
  assign ev_lock    = wr_en && !ev_query && (cur_phase != PH_OPEN) && merged[LOCK_BIT];

  always_comb begin
    nxt_phase = cur_phase;
    nxt_value = cur_value;
    if (ev_query) begin
      nxt_phase = PH_PROBED;
      nxt_value = INRAM_VAL;
    end else if (ev_discard) begin
      nxt_value = '0;
    end else if (ev_lock) begin
      nxt_phase = PH_LOCKED;
      nxt_value = LOCK_MASK;
    end else if (wr_en) begin
      nxt_value = merged;
    end
  end
endmodule

// File: rtl/smb_lock_store.sv
module smb_lock_store
  import smb_lock_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_t       nxt_phase,
  input  logic [W-1:0] nxt_value,
  output phase_t       cur_phase,
  output logic [W-1:0] cur_value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_phase <= PH_OPEN;
      cur_value <= '0;
    end else begin
      cur_phase <= nxt_phase;
      cur_value <= nxt_value;
    end
  end
endmodule

// File: rtl/smb_lock_rdport.sv
module smb_lock_rdport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [W-1:0] value,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= value;
    end
  end
endmodule

// File: rtl/smb_lock_reg.sv
module smb_lock_reg
  import smb_lock_pkg::*;
#(
  parameter int W = REG_W,
  parameter bit FEATURE_EN = 1'b1,
  parameter logic [W-1:0] QUERY_VAL = 8'hFF,
  parameter logic [W-1:0] INRAM_VAL = 8'h01,
  parameter int LOCK_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic [W-1:0] reg_value,
  output logic         blackhole_en,
  output logic         mgmt_window_en
);
  localparam logic [W-1:0] LOCK_VAL = W'(1) << LOCK_BIT;

  logic [W-1:0] value_q;

  generate
    if (FEATURE_EN) begin : g_lock
      phase_t       phase_q, phase_d;
      logic [W-1:0] value_d;
      logic         ev_query, ev_discard, ev_lock;
      logic         locked;

      smb_lock_ctrl #(.W(W), .QUERY_VAL(QUERY_VAL), .INRAM_VAL(INRAM_VAL),
                      .LOCK_BIT(LOCK_BIT)) i_ctrl (
        .cur_phase (phase_q),
        .cur_value (value_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .nxt_phase (phase_d),
        .nxt_value (value_d),
        .ev_query  (ev_query),
        .ev_discard(ev_discard),
        .ev_lock   (ev_lock)
      );

      smb_lock_store #(.W(W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_phase(phase_d),
        .nxt_value(value_d),
        .cur_phase(phase_q),
        .cur_value(value_q)
      );

      assign locked         = (phase_q == PH_LOCKED);
      assign blackhole_en   = locked;
      assign mgmt_window_en = locked;

      assert_query_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_OPEN && wr_data == QUERY_VAL) |=> (value_q == INRAM_VAL));
      assert_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_OPEN && wr_data != QUERY_VAL) |=> (value_q == '0 && !blackhole_en));
      assert_lock_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lock |=> (value_q == LOCK_VAL && blackhole_en));
      assert_probed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_PROBED && !wr_data[LOCK_BIT]) |=> (value_q == INRAM_VAL && !blackhole_en));
      assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blackhole_en |=> (blackhole_en && $stable(value_q)));
      assert_enable_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_window_en) |-> $past(wr_en));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)     value_q <= '0;
        else if (wr_en) value_q <= wr_data;
      end
      assign blackhole_en   = 1'b0;
      assign mgmt_window_en = 1'b0;

      assert_plain_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value_q == $past(wr_data)));
    end
  endgenerate

  smb_lock_rdport #(.W(W)) i_rdport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .value   (value_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  assign reg_value = value_q;

  assert_enables_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blackhole_en == mgmt_window_en);
  assert_read_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid && rd_data == $past(reg_value)));
endmodule

// File: tb/test_smb_lock_reg.sv
module test_smb_lock_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data, rd_data_p, reg_value, reg_value_p;
  logic       rd_valid, rd_valid_p;
  logic       bh, mw, bh_p, mw_p;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // scoreboard entries: expected read value and requirement tag
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // independent model: 0 = never probed, 1 = probed, 2 = locked
  int         m_state = 0;
  logic [7:0] m_val   = 8'h00;
  logic [7:0] m_plain = 8'h00;

  always #10 clk = ~clk;

  smb_lock_reg i_smb_lock_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .reg_value(reg_value),
    .blackhole_en(bh), .mgmt_window_en(mw));

  smb_lock_reg #(.FEATURE_EN(1'b0)) i_smb_lock_reg_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data_p), .rd_valid(rd_valid_p), .reg_value(reg_value_p),
    .blackhole_en(bh_p), .mgmt_window_en(mw_p));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected reads as the design presents them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected read", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 5000", cycles);
      finish_run();
    end
  end

  task automatic do_write(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_plain = d;
    case (m_state)
      0: if (d == 8'hFF) begin m_state = 1; m_val = 8'h01; end else m_val = 8'h00;
      1: if (d[1]) begin m_state = 2; m_val = 8'h02; end
      default: ;
    endcase
  endtask

  task automatic do_read(string req);
    exp_q.push_back(m_val);
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_state(string req);
    check({req, " value"}, reg_value, m_val);
    check({req, " blackhole"}, {7'd0, bh}, {7'd0, m_state == 2});
    check({req, " window"}, {7'd0, mw}, {7'd0, m_state == 2});
    check("R2 plain value", reg_value_p, m_plain);
    check("R2 plain enables", {6'd0, bh_p, mw_p}, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_state = 0; m_val = 8'h00; m_plain = 8'h00;
  endtask

  initial begin
    do_reset();
    check_state("R1 reset");
    do_read("R9 read after reset");
    do_write(8'h55); check_state("R4 discard 55");
    do_write(8'h02); check_state("R4 early lock discarded");
    do_read("R4 readback");
    do_write(8'hFF); check_state("R3 probe");
    do_read("R3 readback");
    do_write(8'hFD); check_state("R6 masked FD");
    do_write(8'h00); check_state("R6 zero write");
    do_read("R6 readback");
    do_write(8'h02); check_state("R5 lock");
    check("R8 enables after lock", {6'd0, bh, mw}, 8'h03);
    do_write(8'h00); check_state("R7 frozen 00");
    do_write(8'hFF); check_state("R7 frozen FF");
    do_read("R7 readback");
    do_reset();
    check_state("R7 reset clears lock");
    do_write(8'hFF); check_state("R3 probe again");
    do_write(8'hFF); check_state("R5 FF locks after probe");
    do_read("R5 readback");
    do_write(8'hA5); check_state("R2 plain store A5");
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule